// File: doc/BRIEF.md
# Wait and stop mode controller

This block sits in the system-integration logic of a small 8-bit microcontroller and owns its two low-power states. When the CPU decodes a wait instruction, the block gates the CPU clock and leaves the peripheral clock running. When the CPU decodes a stop instruction, the block gates both clocks. In either case it pulses a request to clear the CPU's global interrupt mask, so that a later interrupt can bring the CPU back.

In wait state, the CPU wakes on an interrupt request only when three conditions hold together: the request is pending, its enable is set, and its source is marked as running during wait. In stop state, the CPU wakes only on the dedicated external interrupt line. A break request or a reset ends either state. A wake other than reset pulses a stacking-start signal in the cycle after the wake.

A break that ends a low-power state sets a sticky flag in a small status register. Software clears that flag by writing 0 to it. A watchdog enable output follows an option bit, and it is dropped only while the block is in stop state.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, the block is in run state. Both clock enables are 1, `clr_imask_o` and `stack_start_o` are 0, and `brk_stat_o` reads 0.
- R2: When `wait_op_i` is high in run state (and `stop_op_i` is low), the block enters wait state at that clock edge. From the next cycle, `cpu_clk_en_o` is 0 and `per_clk_en_o` stays 1. `clr_imask_o` is 1 for exactly that next cycle.
- R3: When `stop_op_i` is high in run state, the block enters stop state, and this takes priority over `wait_op_i`. Both clock enables go to 0 and `clr_imask_o` pulses for one cycle. While in stop, a high `ext_irq_i` returns the block to run state.
- R4: In wait state, suppose a source i has `irq_req_i[i]`, `irq_en_i[i]` and `irq_wact_i[i]` all at 1. The block then returns to run state at that edge. `stack_start_o` is 1 for exactly the one cycle that follows.
- R5: Some requests must leave the block where it is. In wait state, a request whose enable is 0 is ignored. So is a request whose source is idle in wait (`irq_wact_i[i]` = 0). In stop state, all of `irq_req_i` is ignored.
- R6: `brk_req_i` in wait or stop state returns the block to run state. It pulses `stack_start_o` and sets the stop/wait flag. The flag is bit 1 of the 8-bit `brk_stat_o`, and all other bits read 0. A break in run state changes neither the state nor the flag.
- R7: A write to the flag has the following effects:
  - A write (`stat_wr_i`=1) with `stat_wflag_i`=0 clears the flag.
  - A write with `stat_wflag_i`=1 leaves the flag unchanged.
  - If a flag-setting break and a clearing write fall in the same cycle, the flag ends set.
- R8: `wdog_en_o` equals the inverse of `cop_dis_i` in run and wait states, and it is 0 in stop state.
- R9: Asserting `rst_n` low ends wait or stop state at once, without waiting for a clock. Both clock enables read 1 and the flag reads 0 while reset is held.
- R10: Wait and stop strobes that arrive outside run state are ignored. The block stays in its state and does not pulse `clr_imask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wait_op_i | input | 1 | Decoded wait instruction strobe |
| stop_op_i | input | 1 | Decoded stop instruction strobe |
| irq_req_i | input | N_IRQ | Pending interrupt requests, one per source |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| irq_wact_i | input | N_IRQ | Source keeps running in wait state |
| ext_irq_i | input | 1 | External interrupt line, the only interrupt that ends stop |
| brk_req_i | input | 1 | Break request |
| cop_dis_i | input | 1 | Watchdog-disable option bit |
| stat_wr_i | input | 1 | Write strobe for the break status register |
| stat_wflag_i | input | 1 | Value written to the stop/wait flag |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| clr_imask_o | output | 1 | One-cycle request to clear the interrupt mask |
| stack_start_o | output | 1 | One-cycle request to begin interrupt stacking |
| wdog_en_o | output | 1 | Watchdog run enable |
| brk_stat_o | output | STAT_W | Break status register, stop/wait flag at FLAG_BIT |

## Verification
The bench builds the block with its default parameters:

| Parameter | Value |
|---|---|
| N_IRQ | 4 |
| STAT_W | 8 |
| FLAG_BIT | 1 |
| SYNC_STAGES | 2 |

Four sources are enough for one vector to place a disabled request, a request from an idle source and a qualifying request on different lines. That tells the three wake conditions apart. With the flag at bit 1 of an 8-bit register, a full-byte compare shows both that the flag lands in the right place and that the bits around it stay 0. With a two-stage reset release, the bench can check that the clock enables return at once when reset is asserted, and that the block leaves reset in run state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sh_q;

  // Assert asynchronously, release after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_wact_i,
  input  logic             ext_irq_i,
  output logic             wake_wait_o,
  output logic             wake_stop_o
);

  logic [N_IRQ-1:0] hit;

  // A source may end wait only if it is pending, enabled and still clocked.
  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign hit[g] = irq_req_i[g] & irq_en_i[g] & irq_wact_i[g];
  end

  assign wake_wait_o = |hit;
  // With peripheral clocks off, only the external line can end stop.
  assign wake_stop_o = ext_irq_i;

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_op_i,
  input  logic      stop_op_i,
  input  logic      wake_wait_i,
  input  logic      wake_stop_i,
  input  logic      brk_i,
  output pm_state_e state_o,
  output logic      clr_imask_o,
  output logic      stack_start_o,
  output logic      brk_wake_o
);

  pm_state_e st_q, st_d;
  logic      clr_q, stk_q;
  logic      enter, leave;

  assign enter = (st_q == PM_RUN) && (wait_op_i || stop_op_i);
  assign leave = ((st_q == PM_WAIT) && (wake_wait_i || brk_i)) ||
                 ((st_q == PM_STOP) && (wake_stop_i || brk_i));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RUN: begin
        if (stop_op_i)      st_d = PM_STOP;
        else if (wait_op_i) st_d = PM_WAIT;
      end
      PM_WAIT: if (wake_wait_i || brk_i) st_d = PM_RUN;
      PM_STOP: if (wake_stop_i || brk_i) st_d = PM_RUN;
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PM_RUN;
      clr_q <= 1'b0;
      stk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= enter;
      stk_q <= leave;
    end
  end

  assign state_o       = st_q;
  assign clr_imask_o   = clr_q;
  assign stack_start_o = stk_q;
  assign brk_wake_o    = (st_q != PM_RUN) && brk_i;

  a_r2_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && wait_op_i && !stop_op_i) |=> (st_q == PM_WAIT && clr_q));

  a_r3_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && stop_op_i) |=> (st_q == PM_STOP && clr_q));

  a_r4_stack_next: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_WAIT && wake_wait_i) |=> (stk_q && st_q == PM_RUN));

  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_WAIT && !wake_wait_i && !brk_i) |=> (st_q == PM_WAIT && !stk_q));

  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_STOP && !wake_stop_i && !brk_i) |=> (st_q == PM_STOP && !stk_q));

  a_r10_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PM_RUN) |=> !clr_q);

endmodule

// File: rtl/lpm_brk_stat.sv
module lpm_brk_stat #(
  parameter int STAT_W   = 8,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_wake_i,
  input  logic              wr_i,
  input  logic              wflag_i,
  output logic [STAT_W-1:0] stat_o
);

  logic flag_q, flag_d;

  // A setting break wins over a clearing write in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (brk_wake_i)          flag_d = 1'b1;
    else if (wr_i && !wflag_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    stat_o           = '0;
    stat_o[FLAG_BIT] = flag_q;
  end

  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    brk_wake_i |=> stat_o[FLAG_BIT]);

  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wflag_i && !brk_wake_i) |=> !stat_o[FLAG_BIT]);

  a_r7_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wflag_i && !brk_wake_i) |=> $stable(stat_o[FLAG_BIT]));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int STAT_W      = 8,
  parameter int FLAG_BIT    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_op_i,
  input  logic              stop_op_i,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic [N_IRQ-1:0]  irq_wact_i,
  input  logic              ext_irq_i,
  input  logic              brk_req_i,
  input  logic              cop_dis_i,
  input  logic              stat_wr_i,
  input  logic              stat_wflag_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              clr_imask_o,
  output logic              stack_start_o,
  output logic              wdog_en_o,
  output logic [STAT_W-1:0] brk_stat_o
);

  logic      rst_s_n;
  logic      wake_wait, wake_stop, brk_wake;
  pm_state_e state;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  lpm_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .irq_wact_i  (irq_wact_i),
    .ext_irq_i   (ext_irq_i),
    .wake_wait_o (wake_wait),
    .wake_stop_o (wake_stop)
  );

  lpm_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .wait_op_i     (wait_op_i),
    .stop_op_i     (stop_op_i),
    .wake_wait_i   (wake_wait),
    .wake_stop_i   (wake_stop),
    .brk_i         (brk_req_i),
    .state_o       (state),
    .clr_imask_o   (clr_imask_o),
    .stack_start_o (stack_start_o),
    .brk_wake_o    (brk_wake)
  );

  lpm_brk_stat #(.STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT)) u_stat (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .brk_wake_i (brk_wake),
    .wr_i       (stat_wr_i),
    .wflag_i    (stat_wflag_i),
    .stat_o     (brk_stat_o)
  );

  // Clock enables decode straight from the state register (async reset -> RUN).
  assign cpu_clk_en_o = (state == PM_RUN);
  assign per_clk_en_o = (state != PM_STOP);
  assign wdog_en_o    = !cop_dis_i && (state != PM_STOP);

  a_r8_stop_halts_wdog: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_clk_en_o && stop_op_i) |=> !wdog_en_o);

  a_r6_run_break_inert: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_clk_en_o && brk_req_i && !wait_op_i && !stop_op_i) |=> (cpu_clk_en_o && !stack_start_o));

endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

  localparam int N_IRQ = 4;
  localparam int NV    = 14;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wait_op, stop_op, ext_irq, brk, cop_dis, st_wr, st_wf;
  logic [N_IRQ-1:0] req, en, act;
  logic             cpu_en, per_en, clr, stk, wdg;
  logic [7:0]       stat;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  lpm_ctrl u_lpm_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_op_i     (wait_op),
    .stop_op_i     (stop_op),
    .irq_req_i     (req),
    .irq_en_i      (en),
    .irq_wact_i    (act),
    .ext_irq_i     (ext_irq),
    .brk_req_i     (brk),
    .cop_dis_i     (cop_dis),
    .stat_wr_i     (st_wr),
    .stat_wflag_i  (st_wf),
    .cpu_clk_en_o  (cpu_en),
    .per_clk_en_o  (per_en),
    .clr_imask_o   (clr),
    .stack_start_o (stk),
    .wdog_en_o     (wdg),
    .brk_stat_o    (stat)
  );

  // Fields: tag[27:24] wait stop req[4] en[4] act[4] ext brk copd | cpu per clr stk wdg flg spare
  localparam logic [27:0] VEC [NV] = '{
    {4'd2,  1'b1,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0}, // R2 enter wait
    {4'd5,  1'b0,1'b0,4'hF,4'h0,4'hF,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R5 disabled
    {4'd5,  1'b0,1'b0,4'h1,4'h1,4'h0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R5 idle source
    {4'd10, 1'b1,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R10 op in wait
    {4'd4,  1'b0,1'b0,4'h2,4'h2,4'h2,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0}, // R4 wake
    {4'd4,  1'b0,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R4 single pulse
    {4'd3,  1'b1,1'b1,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 stop wins
    {4'd5,  1'b0,1'b0,4'hF,4'hF,4'hF,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 irq in stop
    {4'd3,  1'b0,1'b0,4'h0,4'h0,4'h0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0}, // R3 ext wake
    {4'd3,  1'b0,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R3 settle
    {4'd8,  1'b1,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 disabled
    {4'd8,  1'b0,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0}, // R8 wait keeps
    {4'd6,  1'b0,1'b0,4'h0,4'h0,4'h0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R6 break wake
    {4'd6,  1'b0,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0}  // R6 sticky
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wait_op = 0; stop_op = 0; ext_irq = 0; brk = 0; cop_dis = 0;
    st_wr = 0; st_wf = 0; req = '0; en = '0; act = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    check("R1", "cpu_en", 32'(cpu_en), 1);
    check("R1", "per_en", 32'(per_en), 1);
    check("R1", "clr",    32'(clr), 0);
    check("R1", "stk",    32'(stk), 0);
    check("R1", "stat",   32'(stat), 0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [27:0] v = VEC[i];
      automatic string tg = $sformatf("R%0d", v[27:24]);
      wait_op = v[23]; stop_op = v[22]; req = v[21:18]; en = v[17:14];
      act = v[13:10]; ext_irq = v[9]; brk = v[8]; cop_dis = v[7];
      step();
      check(tg, $sformatf("vec%0d cpu_en", i), 32'(cpu_en), 32'(v[6]));
      check(tg, $sformatf("vec%0d per_en", i), 32'(per_en), 32'(v[5]));
      check(tg, $sformatf("vec%0d clr", i),    32'(clr),    32'(v[4]));
      check(tg, $sformatf("vec%0d stk", i),    32'(stk),    32'(v[3]));
      check(tg, $sformatf("vec%0d wdog", i),   32'(wdg),    32'(v[2]));
      check(tg, $sformatf("vec%0d stat", i),   32'(stat),   32'({v[1], 1'b0}));
    end
    idle_inputs();

    // R7 writing 1 keeps the flag
    st_wr = 1; st_wf = 1; step(); st_wr = 0;
    check("R7", "write one keeps", 32'(stat), 32'h02);
    // R7 writing 0 clears
    st_wr = 1; st_wf = 0; step(); st_wr = 0;
    check("R7", "write zero clears", 32'(stat), 32'h00);
    // R6 break in run is inert
    brk = 1; step(); brk = 0;
    check("R6", "run break flag", 32'(stat), 32'h00);
    check("R6", "run break cpu", 32'(cpu_en), 1);
    check("R6", "run break stk", 32'(stk), 0);
    // R7 set wins over clear
    wait_op = 1; step(); wait_op = 0;
    check("R2", "wait cpu_en", 32'(cpu_en), 0);
    brk = 1; st_wr = 1; st_wf = 0; step(); brk = 0; st_wr = 0;
    check("R7", "set beats clear", 32'(stat), 32'h02);
    check("R6", "break stack", 32'(stk), 1);
    // R9 async reset ends wait at once
    wait_op = 1; step(); wait_op = 0;
    check("R9", "in wait before reset", 32'(cpu_en), 0);
    #2 rst_n = 1'b0;
    #1;
    check("R9", "cpu_en under reset", 32'(cpu_en), 1);
    check("R9", "per_en under reset", 32'(per_en), 1);
    check("R9", "flag under reset", 32'(stat), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1", "post reset cpu_en", 32'(cpu_en), 1);
    check("R1", "post reset stk", 32'(stk), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule